// File: doc/BRIEF.md
# Protection Entry CSR Bank

This block stores the per-entry state of a memory-protection unit: one 8-bit configuration byte and one address register for each of a fixed number of entries. Software reaches it through a single CSR-style port. A select input chooses between the configuration space and the address space, and an index input chooses the register. Configuration bytes are packed several to a CSR word. Each byte position in the word maps to one entry. Address registers map one per index.

All entry registers are driven out in parallel on flat buses, so the separate range-decode and permission-check logic can read every entry at once. A count of entries whose match mode is not off is also driven out.

Writes are filtered by a lock rule. An entry refuses writes when its own lock bit is set. It also refuses writes when the entry above it is locked and uses top-of-range matching, because this entry's address then serves as the lower bound of that locked range. Reads are combinational. Writes take effect at the next rising clock edge.

Top module: `pe_csr_bank`

## Requirements
- R1: After an active-low reset, every configuration byte, every address register, the active count and all read data are zero.
- R2: A configuration write to CSR index r puts byte i of the write data (bits 8i+7..8i) into entry 4r+i, for each byte of the register width. Configuration byte fields are:
  - bits 4:3 give the match mode: 0 off, 1 top-of-range, 2 aligned 4-byte, 3 aligned power-of-two.
  - bits 2:0 grant read, write and execute.
  - bit 7 is the lock.
- R3: A configuration read of index r returns entry 4r+i in byte i. Byte positions that map past the last entry read as zero, and writes to them change nothing.
- R4: While an entry's lock bit (bit 7) is set, writes to its configuration byte and to its address register are ignored.
- R5: While entry k+1 has lock set and match mode 1, writes to entry k's configuration byte and address register are ignored. A locked entry k+1 in any other mode does not protect entry k.
- R6: The highest-numbered entry is protected only by its own lock bit.
- R7: An address write to index k stores the full word into entry k. An address access to an index at or past the entry count is ignored on write and reads as zero.
- R8: With a 64-bit register width, a configuration write to an odd CSR index changes no entry, while an even index r writes eight entries starting at 4r.
- R9: The active count equals the number of entries whose match mode is not 0. It reflects an accepted write from the cycle after that write and does not change in a cycle that follows no write.
- R10: Entry k's configuration byte appears on `entry_cfg_o[8k+7:8k]` and its address register on `entry_addr_o[XLEN*k+XLEN-1:XLEN*k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_we | input | 1 | Write strobe for the current CSR access |
| csr_sel_cfg | input | 1 | 1 selects configuration space, 0 selects address space |
| csr_idx | input | IDX_W | CSR index within the selected space |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for the current index, combinational |
| entry_cfg_o | output | 8*N_ENTRIES | All configuration bytes, entry k at bits 8k+7:8k |
| entry_addr_o | output | XLEN*N_ENTRIES | All address registers, entry k in slice k |
| active_cnt_o | output | CNT_W | Number of entries whose match mode is not off |

## Verification
The properties assume that the strobe, select, index and write data are known, two-state values whenever reset is released. They also assume that these inputs change only between rising edges, so that a write is seen exactly once. The stimulus drives every input from time zero and changes it just after a rising edge. It holds the strobe high for a single cycle per write. Random phases pick indices both inside and past the implemented range, and reset is reapplied between phases so that accumulated locks do not freeze the whole bank.

// File: rtl/pecb_pkg.sv
package pecb_pkg;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_mode_e;

    localparam int CFG_W           = 8;
    localparam int LOCK_POS        = 7;
    localparam int MODE_LSB        = 3;
    localparam int ENTRIES_PER_IDX = 4;

    function automatic match_mode_e mode_of(input logic [CFG_W-1:0] c);
        return match_mode_e'(c[MODE_LSB +: 2]);
    endfunction

    function automatic logic lock_of(input logic [CFG_W-1:0] c);
        return c[LOCK_POS];
    endfunction

endpackage

// File: rtl/pecb_guard.sv
// Per-entry write protection: own lock, or upper neighbour locked in TOR mode.
module pecb_guard
    import pecb_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N*CFG_W-1:0] cfg_flat,
    output logic [N-1:0]       blocked
);

    logic guard_unused;
    assign guard_unused = ^cfg_flat;

    for (genvar k = 0; k < N; k++) begin : g_entry
        if (k == N - 1) begin : g_top
            assign blocked[k] = lock_of(cfg_flat[k*CFG_W +: CFG_W]);
        end else begin : g_mid
            assign blocked[k] = lock_of(cfg_flat[k*CFG_W +: CFG_W])
                              | (lock_of(cfg_flat[(k+1)*CFG_W +: CFG_W])
                                 & (mode_of(cfg_flat[(k+1)*CFG_W +: CFG_W]) == MATCH_TOR));
        end
    end

endmodule

// File: rtl/pecb_wdec.sv
// Turns one CSR write into per-entry write enables and byte lanes.
module pecb_wdec
    import pecb_pkg::*;
#(
    parameter int N     = 16,
    parameter int XLEN  = 32,
    parameter int IDX_W = 8
) (
    input  logic                 csr_we,
    input  logic                 csr_sel_cfg,
    input  logic [IDX_W-1:0]     csr_idx,
    input  logic [XLEN-1:0]      csr_wdata,
    input  logic [N-1:0]         blocked,
    output logic [N-1:0]         cfg_we,
    output logic [N*CFG_W-1:0]   cfg_wbyte,
    output logic [N-1:0]         addr_we
);

    localparam int BPW      = XLEN / CFG_W;
    localparam int IDX_STEP = BPW / ENTRIES_PER_IDX;

    logic odd_reject;
    logic cfg_write;
    logic addr_write;

    assign odd_reject = (XLEN == 64) && csr_idx[0];
    assign cfg_write  = csr_we &&  csr_sel_cfg && !odd_reject;
    assign addr_write = csr_we && !csr_sel_cfg;

    for (genvar k = 0; k < N; k++) begin : g_entry
        localparam int ROW  = (k / BPW) * IDX_STEP;
        localparam int LANE = k % BPW;
        localparam logic [IDX_W-1:0] ROW_IDX = IDX_W'(ROW);
        localparam logic [IDX_W-1:0] OWN_IDX = IDX_W'(k);

        assign cfg_we[k]  = cfg_write && (csr_idx == ROW_IDX) && !blocked[k];
        assign cfg_wbyte[k*CFG_W +: CFG_W] = csr_wdata[LANE*CFG_W +: CFG_W];
        assign addr_we[k] = addr_write && (csr_idx == OWN_IDX) && !blocked[k];
    end

endmodule

// File: rtl/pecb_rmux.sv
// Combinational CSR read path.
module pecb_rmux
    import pecb_pkg::*;
#(
    parameter int N     = 16,
    parameter int XLEN  = 32,
    parameter int IDX_W = 8
) (
    input  logic                 csr_sel_cfg,
    input  logic [IDX_W-1:0]     csr_idx,
    input  logic [N*CFG_W-1:0]   cfg_flat,
    input  logic [N*XLEN-1:0]    addr_flat,
    output logic [XLEN-1:0]      csr_rdata
);

    localparam int BPW = XLEN / CFG_W;

    always_comb begin
        int e;
        int base;
        csr_rdata = '0;
        e         = 0;
        base      = int'(csr_idx) * ENTRIES_PER_IDX;
        if (csr_sel_cfg) begin
            for (int i = 0; i < BPW; i++) begin
                e = base + i;
                if (e < N) begin
                    csr_rdata[i*CFG_W +: CFG_W] = cfg_flat[e*CFG_W +: CFG_W];
                end
            end
        end else if (int'(csr_idx) < N) begin
            csr_rdata = addr_flat[int'(csr_idx)*XLEN +: XLEN];
        end
    end

endmodule

// File: rtl/pecb_active_cnt.sv
// Population count of entries whose match mode is not off.
module pecb_active_cnt
    import pecb_pkg::*;
#(
    parameter int N     = 16,
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic [N*CFG_W-1:0] cfg_flat,
    output logic [CNT_W-1:0]   count
);

    logic cnt_unused;
    assign cnt_unused = ^cfg_flat;

    always_comb begin
        count = '0;
        for (int k = 0; k < N; k++) begin
            if (mode_of(cfg_flat[k*CFG_W +: CFG_W]) != MATCH_OFF) begin
                count = count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/pe_csr_bank.sv
module pe_csr_bank
    import pecb_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int XLEN      = 32,
    parameter int IDX_W     = 8,
    parameter int CNT_W     = $clog2(N_ENTRIES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       csr_we,
    input  logic                       csr_sel_cfg,
    input  logic [IDX_W-1:0]           csr_idx,
    input  logic [XLEN-1:0]            csr_wdata,
    output logic [XLEN-1:0]            csr_rdata,
    output logic [N_ENTRIES*8-1:0]     entry_cfg_o,
    output logic [N_ENTRIES*XLEN-1:0]  entry_addr_o,
    output logic [CNT_W-1:0]           active_cnt_o
);

    logic [CFG_W-1:0]         cfg_q  [N_ENTRIES];
    logic [XLEN-1:0]          addr_q [N_ENTRIES];
    logic [N_ENTRIES-1:0]     blocked;
    logic [N_ENTRIES-1:0]     cfg_we;
    logic [N_ENTRIES-1:0]     addr_we;
    logic [N_ENTRIES*CFG_W-1:0] cfg_wbyte;

    pecb_guard #(.N(N_ENTRIES)) guard_i (
        .cfg_flat (entry_cfg_o),
        .blocked  (blocked)
    );

    pecb_wdec #(.N(N_ENTRIES), .XLEN(XLEN), .IDX_W(IDX_W)) wdec_i (
        .csr_we      (csr_we),
        .csr_sel_cfg (csr_sel_cfg),
        .csr_idx     (csr_idx),
        .csr_wdata   (csr_wdata),
        .blocked     (blocked),
        .cfg_we      (cfg_we),
        .cfg_wbyte   (cfg_wbyte),
        .addr_we     (addr_we)
    );

    for (genvar k = 0; k < N_ENTRIES; k++) begin : g_store
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[k]  <= '0;
                addr_q[k] <= '0;
            end else begin
                if (cfg_we[k]) begin
                    cfg_q[k] <= cfg_wbyte[k*CFG_W +: CFG_W];
                end
                if (addr_we[k]) begin
                    addr_q[k] <= csr_wdata;
                end
            end
        end
        assign entry_cfg_o[k*CFG_W +: CFG_W] = cfg_q[k];
        assign entry_addr_o[k*XLEN +: XLEN]  = addr_q[k];
    end

    pecb_rmux #(.N(N_ENTRIES), .XLEN(XLEN), .IDX_W(IDX_W)) rmux_i (
        .csr_sel_cfg (csr_sel_cfg),
        .csr_idx     (csr_idx),
        .cfg_flat    (entry_cfg_o),
        .addr_flat   (entry_addr_o),
        .csr_rdata   (csr_rdata)
    );

    pecb_active_cnt #(.N(N_ENTRIES), .CNT_W(CNT_W)) cnt_i (
        .cfg_flat (entry_cfg_o),
        .count    (active_cnt_o)
    );

endmodule

// File: rtl/pe_csr_bank_chk.sv
module pe_csr_bank_chk #(
    parameter int N     = 16,
    parameter int XLEN  = 32,
    parameter int IDX_W = 8,
    parameter int CNT_W = $clog2(N + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 csr_we,
    input logic                 csr_sel_cfg,
    input logic [IDX_W-1:0]     csr_idx,
    input logic [XLEN-1:0]      csr_rdata,
    input logic [N*8-1:0]       entry_cfg_o,
    input logic [N*XLEN-1:0]    entry_addr_o,
    input logic [CNT_W-1:0]     active_cnt_o
);

    for (genvar k = 0; k < N; k++) begin : g_lock
        // R4: a set lock freezes the entry's own registers
        p_own_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(entry_cfg_o[k*8+7])
            |-> ($stable(entry_cfg_o[k*8 +: 8]) && $stable(entry_addr_o[k*XLEN +: XLEN])));

        if (k < N - 1) begin : g_tor
            // R5: a locked TOR neighbour above freezes this entry
            p_tor_shield_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $past(entry_cfg_o[(k+1)*8+7] && (entry_cfg_o[(k+1)*8+3 +: 2] == 2'd1))
                |-> ($stable(entry_cfg_o[k*8 +: 8]) && $stable(entry_addr_o[k*XLEN +: XLEN])));
        end
    end

    // R7: out-of-range address write touches nothing
    p_addr_oob_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && !csr_sel_cfg && (int'(csr_idx) >= N)) |=> $stable(entry_addr_o));

    // R7: out-of-range address read returns zero
    p_addr_oob_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_sel_cfg && (int'(csr_idx) >= N)) |-> (csr_rdata == '0));

    // R8: odd configuration index ignored at 64-bit width
    p_odd_cfg64_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((XLEN == 64) && csr_we && csr_sel_cfg && csr_idx[0]) |=> $stable(entry_cfg_o));

    // R9: count moves only after a write, and never exceeds the entry count
    p_cnt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(csr_we) |-> $stable(active_cnt_o));

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(active_cnt_o) <= N);

endmodule

bind pe_csr_bank pe_csr_bank_chk #(
    .N     (N_ENTRIES),
    .XLEN  (XLEN),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_we       (csr_we),
    .csr_sel_cfg  (csr_sel_cfg),
    .csr_idx      (csr_idx),
    .csr_rdata    (csr_rdata),
    .entry_cfg_o  (entry_cfg_o),
    .entry_addr_o (entry_addr_o),
    .active_cnt_o (active_cnt_o)
);

// File: tb/pe_csr_bank_ref.sv
// Behavioural reference: arrays, integer loops, lock rule evaluated on pre-write state.
module pe_csr_bank_ref #(
    parameter int N     = 16,
    parameter int XLEN  = 32,
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               sel_cfg,
    input  logic [IDX_W-1:0]   idx,
    input  logic [XLEN-1:0]    wdata,
    output logic [N*8-1:0]     exp_cfg,
    output logic [N*XLEN-1:0]  exp_addr,
    output int                 exp_cnt,
    output logic [XLEN-1:0]    exp_rdata
);

    logic [7:0]      cfg_m  [N];
    logic [XLEN-1:0] addr_m [N];

    function automatic bit frozen(int k);
        bit f;
        f = cfg_m[k][7];
        if (k + 1 < N) begin
            if (cfg_m[k+1][7] && (cfg_m[k+1][4:3] == 2'b01)) f = 1'b1;
        end
        return f;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) begin
                cfg_m[k]  <= 8'h00;
                addr_m[k] <= '0;
            end
        end else if (we) begin
            if (sel_cfg) begin
                if (!((XLEN == 64) && idx[0])) begin
                    for (int i = 0; i < XLEN / 8; i++) begin
                        int e;
                        e = int'(idx) * 4 + i;
                        if (e < N && !frozen(e)) cfg_m[e] <= wdata[i*8 +: 8];
                    end
                end
            end else if (int'(idx) < N) begin
                if (!frozen(int'(idx))) addr_m[int'(idx)] <= wdata;
            end
        end
    end

    always @* begin
        exp_cnt   = 0;
        exp_rdata = '0;
        for (int k = 0; k < N; k++) begin
            exp_cfg[k*8 +: 8]        = cfg_m[k];
            exp_addr[k*XLEN +: XLEN] = addr_m[k];
            if (cfg_m[k][4:3] != 2'b00) exp_cnt = exp_cnt + 1;
        end
        if (sel_cfg) begin
            for (int i = 0; i < XLEN / 8; i++) begin
                int e;
                e = int'(idx) * 4 + i;
                if (e < N) exp_rdata[i*8 +: 8] = cfg_m[e];
            end
        end else if (int'(idx) < N) begin
            exp_rdata = addr_m[int'(idx)];
        end
    end

endmodule

// File: tb/pe_csr_bank_tb_top.sv
module pe_csr_bank_tb_top;

    localparam int N     = 16;
    localparam int IDX_W = 8;
    localparam int CW    = $clog2(N + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              we = 1'b0;
    logic              sel = 1'b0;
    logic [IDX_W-1:0]  idx = '0;
    logic [63:0]       wdata = '0;

    logic [31:0]       rd32;
    logic [N*8-1:0]    cfg32;
    logic [N*32-1:0]   addr32;
    logic [CW-1:0]     cnt32;
    logic [63:0]       rd64;
    logic [N*8-1:0]    cfg64;
    logic [N*64-1:0]   addr64;
    logic [CW-1:0]     cnt64;

    logic [31:0]       e_rd32;
    logic [N*8-1:0]    e_cfg32;
    logic [N*32-1:0]   e_addr32;
    int                e_cnt32;
    logic [63:0]       e_rd64;
    logic [N*8-1:0]    e_cfg64;
    logic [N*64-1:0]   e_addr64;
    int                e_cnt64;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  cmp_on   = 1'b0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    pe_csr_bank #(.N_ENTRIES(N), .XLEN(32), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_we(we), .csr_sel_cfg(sel), .csr_idx(idx),
        .csr_wdata(wdata[31:0]), .csr_rdata(rd32), .entry_cfg_o(cfg32),
        .entry_addr_o(addr32), .active_cnt_o(cnt32)
    );

    pe_csr_bank #(.N_ENTRIES(N), .XLEN(64), .IDX_W(IDX_W)) dut64_i (
        .clk(clk), .rst_n(rst_n), .csr_we(we), .csr_sel_cfg(sel), .csr_idx(idx),
        .csr_wdata(wdata), .csr_rdata(rd64), .entry_cfg_o(cfg64),
        .entry_addr_o(addr64), .active_cnt_o(cnt64)
    );

    pe_csr_bank_ref #(.N(N), .XLEN(32), .IDX_W(IDX_W)) ref32_i (
        .clk(clk), .rst_n(rst_n), .we(we), .sel_cfg(sel), .idx(idx), .wdata(wdata[31:0]),
        .exp_cfg(e_cfg32), .exp_addr(e_addr32), .exp_cnt(e_cnt32), .exp_rdata(e_rd32)
    );

    pe_csr_bank_ref #(.N(N), .XLEN(64), .IDX_W(IDX_W)) ref64_i (
        .clk(clk), .rst_n(rst_n), .we(we), .sel_cfg(sel), .idx(idx), .wdata(wdata),
        .exp_cfg(e_cfg64), .exp_addr(e_addr64), .exp_cnt(e_cnt64), .exp_rdata(e_rd64)
    );

    task automatic check(input string tag, input logic [1023:0] act, input logic [1023:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference comparison on every clock, away from the rising edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R10 cfg bus 32",  1024'(cfg32),  1024'(e_cfg32));
            check("R10 addr bus 32", 1024'(addr32), 1024'(e_addr32));
            check("R9 count 32",     1024'(cnt32),  1024'(e_cnt32));
            check("R3 rdata 32",     1024'(rd32),   1024'(e_rd32));
            check("R10 cfg bus 64",  1024'(cfg64),  1024'(e_cfg64));
            check("R10 addr bus 64", 1024'(addr64), 1024'(e_addr64));
            check("R9 count 64",     1024'(cnt64),  1024'(e_cnt64));
            check("R3 rdata 64",     1024'(rd64),   1024'(e_rd64));
        end
    end

    task automatic do_reset();
        @(posedge clk); #1;
        we = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic csr_write(input logic s, input int i, input logic [63:0] d);
        @(posedge clk); #1;
        we = 1'b1; sel = s; idx = IDX_W'(i); wdata = d;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic csr_read32(input logic s, input int i, output logic [31:0] v);
        we = 1'b0; sel = s; idx = IDX_W'(i);
        @(negedge clk);
        v = rd32;
    endtask

    initial begin
        logic [31:0]     v;
        logic [N*32-1:0] snap_a;
        logic [N*8-1:0]  snap_c;
        do_reset();
        cmp_on = 1'b1;

        // R1: reset state
        @(negedge clk);
        check("R1 cfg zero",   1024'(cfg32),  1024'(0));
        check("R1 addr zero",  1024'(addr32), 1024'(0));
        check("R1 count zero", 1024'(cnt32),  1024'(0));
        check("R1 cfg64 zero", 1024'(cfg64),  1024'(0));

        // R8: odd index at 64-bit width is dropped; 32-bit bank accepts it
        csr_write(1'b1, 1, 64'h0000_0000_0707_0707);
        @(negedge clk);
        check("R8 odd idx ignored 64", 1024'(cfg64), 1024'(0));
        csr_read32(1'b1, 1, v);
        check("R2 idx1 bytes 32", 1024'(v), 1024'(32'h0707_0707));
        csr_write(1'b1, 0, 64'h1818_1818_0808_0808);
        @(negedge clk);
        check("R8 even idx eight entries 64", 1024'(cfg64[63:0]), 1024'(64'h1818_1818_0808_0808));
        check("R9 count 64 after write", 1024'(cnt64), 1024'(8));
        check("R9 count 32 after write", 1024'(cnt32), 1024'(4));

        do_reset();
        @(negedge clk);
        check("R1 reset clears cfg",  1024'(cfg32), 1024'(0));
        check("R1 reset clears cnt",  1024'(cnt32), 1024'(0));

        // R2 / R9: byte split and active count
        csr_write(1'b1, 0, 64'h1810_0807);
        @(negedge clk);
        check("R2 entry1 byte", 1024'(cfg32[15:8]), 1024'(8'h08));
        check("R10 entry3 slice", 1024'(cfg32[31:24]), 1024'(8'h18));
        check("R9 count three", 1024'(cnt32), 1024'(3));
        csr_read32(1'b1, 0, v);
        check("R3 cfg read idx0", 1024'(v), 1024'(32'h1810_0807));

        // R7: address space
        csr_write(1'b0, 5, 64'h1234_5678);
        csr_read32(1'b0, 5, v);
        check("R7 addr5 readback", 1024'(v), 1024'(32'h1234_5678));
        snap_a = addr32;
        csr_write(1'b0, 16, 64'hDEAD_BEEF);
        @(negedge clk);
        check("R7 oob addr write ignored", 1024'(addr32), 1024'(snap_a));
        csr_read32(1'b0, 16, v);
        check("R7 oob addr read zero", 1024'(v), 1024'(0));

        // R3: configuration bytes past the last entry
        snap_c = cfg32;
        csr_write(1'b1, 4, 64'hFFFF_FFFF);
        @(negedge clk);
        check("R3 oob cfg write ignored", 1024'(cfg32), 1024'(snap_c));
        check("R9 count unchanged", 1024'(cnt32), 1024'(3));
        csr_read32(1'b1, 4, v);
        check("R3 oob cfg read zero", 1024'(v), 1024'(0));

        // R4: own lock
        csr_write(1'b1, 1, 64'h0000_0080);
        csr_write(1'b0, 4, 64'h0000_0055);
        csr_read32(1'b0, 4, v);
        check("R4 locked addr write ignored", 1024'(v), 1024'(0));
        csr_write(1'b1, 1, 64'h0000_0001);
        csr_read32(1'b1, 1, v);
        check("R4 locked cfg write ignored", 1024'(v), 1024'(32'h0000_0080));

        // R5: locked TOR neighbour shields entry 8
        csr_write(1'b1, 2, 64'h0000_8800);
        @(negedge clk);
        check("R9 count four", 1024'(cnt32), 1024'(4));
        csr_write(1'b0, 8, 64'h0000_00AA);
        csr_read32(1'b0, 8, v);
        check("R5 tor shield addr", 1024'(v), 1024'(0));
        csr_write(1'b1, 2, 64'h0000_881F);
        csr_read32(1'b1, 2, v);
        check("R5 tor shield cfg", 1024'(v), 1024'(32'h0000_8800));

        // R5: locked neighbour in non-TOR mode does not shield
        csr_write(1'b1, 3, 64'h0000_9000);
        @(negedge clk);
        check("R9 count five", 1024'(cnt32), 1024'(5));
        csr_write(1'b0, 12, 64'h0000_0033);
        csr_read32(1'b0, 12, v);
        check("R5 na4 neighbour no shield", 1024'(v), 1024'(32'h0000_0033));

        // R6: highest entry has no upper neighbour
        csr_write(1'b0, 15, 64'h0000_0077);
        csr_read32(1'b0, 15, v);
        check("R6 top entry writable", 1024'(v), 1024'(32'h0000_0077));

        // Random phases checked against the reference every clock
        for (int round = 0; round < 4; round++) begin
            do_reset();
            for (int n = 0; n < 100; n++) begin
                @(posedge clk); #1;
                we    = ($urandom_range(0, 3) != 0);
                sel   = $urandom_range(0, 1) == 1;
                idx   = IDX_W'($urandom_range(0, (round == 3) ? 20 : 5));
                wdata = {$urandom, $urandom};
            end
            @(posedge clk); #1 we = 1'b0;
        end

        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule